// File: doc/BRIEF.md
# SIMD Vector Register File

This block stores the vector operands of a short-vector floating-point unit. It holds eight registers of 128 bits, each split into four 32-bit single-precision lanes, and picks registers by a plain 3-bit index. Two read ports return the two source operands of an operation in the same cycle. One write port puts the result back.

Operations use a destructive two-operand form, so the block has no separate destination index. A write always lands in the register selected by the first source index. The write port has two modes. A packed write replaces the whole register. A scalar write changes only lane 0 and leaves the upper three lanes as they were.

If a read port selects the register being written in that cycle, it returns the value the register will hold after the clock edge. In scalar mode that means the new lane 0 joined to the three old upper lanes. The arithmetic, the memory path and the saving of state across context switches sit outside this block.

Top module: `vec_regfile`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every register is cleared to zero. This takes priority over a write in the same cycle.
- R2: A packed write (`wr_en`=1, `wr_scalar`=0) replaces all 128 bits of the destination at the rising edge.
- R3: A scalar write (`wr_en`=1, `wr_scalar`=1) replaces only bits 31:0 of the destination. Bits 127:32 keep their previous value.
- R4: The destination of every write is the register selected by `src_a_idx`. No other register changes.
- R5: When `wr_en` is low at a rising edge, no register changes, whatever is on `wr_data`, `wr_scalar` and the indices.
- R6: In a cycle with `wr_en` high, `rd_a_data` already shows the post-write value of the destination: `wr_data` in packed mode, or the old bits 127:32 with `wr_data[31:0]` in scalar mode.
- R7: When `wr_en` is high and `src_b_idx` equals `src_a_idx`, `rd_b_data` returns the same post-write value as in R6.
- R8: With no write to the selected register, each read port returns the stored contents of the register at its own index. The two ports select independently in the same cycle.
- R9: Lane k sits at bits 32k+31 down to 32k of every data port and register, so lane 0 is bits 31:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_a_idx | input | 3 | First source index; also the write destination |
| src_b_idx | input | 3 | Second source index |
| wr_en | input | 1 | Write enable, sampled at the rising edge |
| wr_scalar | input | 1 | 1 = scalar write (lane 0 only), 0 = packed write |
| wr_data | input | 128 | Result vector to write |
| rd_a_data | output | 128 | First source operand, with bypass |
| rd_b_data | output | 128 | Second source operand, with bypass |

## Verification
The read ports are combinational, so a bypassed value is due in the same cycle as the write request. A stored value is due from the cycle after the rising edge that captured it. The bench drives every input just after a falling edge and compares both read ports one time unit later, before the next rising edge. At that point it checks the bypassed value against its own model's post-write value. It then updates that model at the rising edge, so the next operation's reads check what was stored. Reset is checked in the same way: the bench reads every register back in the cycles after reset is released.

// File: rtl/vrf_pkg.sv
// Package: shared sizes and the write-mode encoding of the vector register file.
// Assumes: lanes are equal width and the register count is a power of two.
package vrf_pkg;

    parameter int VRF_NUM_REGS = 8;
    parameter int VRF_LANES    = 4;
    parameter int VRF_LANE_W   = 32;

    // Write mode as carried on the wr_scalar pin.
    typedef enum logic {
        WR_PACKED = 1'b0,
        WR_SCALAR = 1'b1
    } wr_mode_e;

endpackage

// File: rtl/vrf_lane_mask.sv
// Module: turns the write enable and the write mode into one write enable per lane.
// Assumes: lane 0 is the scalar lane; a packed write enables every lane.
module vrf_lane_mask #(
    parameter int LANES = vrf_pkg::VRF_LANES
) (
    input  logic             wr_en,
    input  logic             wr_scalar,
    output logic [LANES-1:0] lane_we
);

    vrf_pkg::wr_mode_e mode;

    // Decode the mode pin into the enum.
    always_comb mode = vrf_pkg::wr_mode_e'(wr_scalar);

    // Select the lanes that a write touches.
    always_comb begin
        lane_we = '0;
        if (wr_en) begin
            if (mode == vrf_pkg::WR_SCALAR) lane_we[0] = 1'b1;
            else                            lane_we    = '1;
        end
    end

endmodule

// File: rtl/vrf_storage.sv
// Module: register array of NUM_REGS vectors. Each lane of each register is a
//         separate flop group with its own enable.
// Assumes: synchronous active-low reset to zero, which has priority over writes.
module vrf_storage #(
    parameter int NUM_REGS = vrf_pkg::VRF_NUM_REGS,
    parameter int LANES    = vrf_pkg::VRF_LANES,
    parameter int LANE_W   = vrf_pkg::VRF_LANE_W,
    localparam int VEC_W   = LANES * LANE_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [LANES-1:0]               lane_we,
    input  logic [VEC_W-1:0]               wr_data,
    output logic [NUM_REGS-1:0][VEC_W-1:0] regs_q
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic reg_sel;

        // Flag whether this register is the write destination.
        always_comb reg_sel = (wr_idx == IDX_W'(r));

        for (genvar l = 0; l < LANES; l++) begin : g_lane
            // Hold, clear or load one lane of one register.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_q[r][l*LANE_W +: LANE_W] <= '0;
                else if (reg_sel && lane_we[l])
                    regs_q[r][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
            end
        end
    end

endmodule

// File: rtl/vrf_read_port.sv
// Module: one read port. It selects a register and swaps in the write data for
//         each lane that this cycle's write is about to change.
// Assumes: lane_we is all zero when no write is in progress.
module vrf_read_port #(
    parameter int NUM_REGS = vrf_pkg::VRF_NUM_REGS,
    parameter int LANES    = vrf_pkg::VRF_LANES,
    parameter int LANE_W   = vrf_pkg::VRF_LANE_W,
    localparam int VEC_W   = LANES * LANE_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0]               rd_idx,
    input  logic [NUM_REGS-1:0][VEC_W-1:0] regs_q,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [LANES-1:0]               lane_we,
    input  logic [VEC_W-1:0]               wr_data,
    output logic [VEC_W-1:0]               rd_data
);

    logic [VEC_W-1:0] stored;
    logic             same_reg;

    // Select the stored vector and compare the read index with the write index.
    always_comb begin
        stored   = regs_q[rd_idx];
        same_reg = (rd_idx == wr_idx);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_byp
        // Forward this lane from the write data when it is being written.
        always_comb begin
            if (same_reg && lane_we[l])
                rd_data[l*LANE_W +: LANE_W] = wr_data[l*LANE_W +: LANE_W];
            else
                rd_data[l*LANE_W +: LANE_W] = stored[l*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/vec_regfile.sv
// Module: top of the vector register file. It has two read ports with bypass
//         and one write port. The write destination is the first source index.
// Assumes: one write per cycle; reads are combinational from the indices.
module vec_regfile #(
    parameter int NUM_REGS = vrf_pkg::VRF_NUM_REGS,
    parameter int LANES    = vrf_pkg::VRF_LANES,
    parameter int LANE_W   = vrf_pkg::VRF_LANE_W,
    localparam int VEC_W   = LANES * LANE_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] src_a_idx,
    input  logic [IDX_W-1:0] src_b_idx,
    input  logic             wr_en,
    input  logic             wr_scalar,
    input  logic [VEC_W-1:0] wr_data,
    output logic [VEC_W-1:0] rd_a_data,
    output logic [VEC_W-1:0] rd_b_data
);

    logic [LANES-1:0]               lane_we;
    logic [NUM_REGS-1:0][VEC_W-1:0] regs_q;

    vrf_lane_mask #(.LANES(LANES)) i_mask (
        .wr_en     (wr_en),
        .wr_scalar (wr_scalar),
        .lane_we   (lane_we)
    );

    vrf_storage #(.NUM_REGS(NUM_REGS), .LANES(LANES), .LANE_W(LANE_W)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_idx  (src_a_idx),
        .lane_we (lane_we),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    vrf_read_port #(.NUM_REGS(NUM_REGS), .LANES(LANES), .LANE_W(LANE_W)) i_rd_a (
        .rd_idx  (src_a_idx),
        .regs_q  (regs_q),
        .wr_idx  (src_a_idx),
        .lane_we (lane_we),
        .wr_data (wr_data),
        .rd_data (rd_a_data)
    );

    vrf_read_port #(.NUM_REGS(NUM_REGS), .LANES(LANES), .LANE_W(LANE_W)) i_rd_b (
        .rd_idx  (src_b_idx),
        .regs_q  (regs_q),
        .wr_idx  (src_a_idx),
        .lane_we (lane_we),
        .wr_data (wr_data),
        .rd_data (rd_b_data)
    );

endmodule

// File: rtl/vrf_checker.sv
// Module: assertion checker for vec_regfile, attached with the bind below.
// Assumes: it sees the register array of the top through the bind connection.
module vrf_checker #(
    parameter int NUM_REGS = vrf_pkg::VRF_NUM_REGS,
    parameter int LANES    = vrf_pkg::VRF_LANES,
    parameter int LANE_W   = vrf_pkg::VRF_LANE_W,
    localparam int VEC_W   = LANES * LANE_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [IDX_W-1:0]               src_a_idx,
    input logic [IDX_W-1:0]               src_b_idx,
    input logic                           wr_en,
    input logic                           wr_scalar,
    input logic [VEC_W-1:0]               wr_data,
    input logic [VEC_W-1:0]               rd_a_data,
    input logic [VEC_W-1:0]               rd_b_data,
    input logic [NUM_REGS-1:0][VEC_W-1:0] regs_q
);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (regs_q == '0));

    a_r2_packed_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_scalar) |=> (regs_q[$past(src_a_idx)] == $past(wr_data)));

    a_r3_scalar_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_scalar) |=>
        (regs_q[$past(src_a_idx)][VEC_W-1:LANE_W] == $past(regs_q[src_a_idx][VEC_W-1:LANE_W])));

    a_r3_scalar_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_scalar) |=>
        (regs_q[$past(src_a_idx)][LANE_W-1:0] == $past(wr_data[LANE_W-1:0])));

    a_r5_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));

    a_r6_bypass_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (rd_a_data[LANE_W-1:0] == wr_data[LANE_W-1:0]));

    a_r7_bypass_b_matches_a: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (src_b_idx == src_a_idx)) |-> (rd_b_data == rd_a_data));

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_other
        a_r4_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (src_a_idx != IDX_W'(g)) |=> $stable(regs_q[g]));
    end

endmodule

bind vec_regfile vrf_checker #(
    .NUM_REGS (NUM_REGS),
    .LANES    (LANES),
    .LANE_W   (LANE_W)
) i_vrf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_a_idx (src_a_idx),
    .src_b_idx (src_b_idx),
    .wr_en     (wr_en),
    .wr_scalar (wr_scalar),
    .wr_data   (wr_data),
    .rd_a_data (rd_a_data),
    .rd_b_data (rd_b_data),
    .regs_q    (regs_q)
);

// File: tb/test_vec_regfile.sv
module test_vec_regfile;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   src_a_idx = '0;
    logic [2:0]   src_b_idx = '0;
    logic         wr_en = 1'b0;
    logic         wr_scalar = 1'b0;
    logic [127:0] wr_data = '0;
    logic [127:0] rd_a_data;
    logic [127:0] rd_b_data;

    int checks = 0;
    int errors = 0;
    logic [127:0] model [NREG];

    vec_regfile i_vec_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_a_idx (src_a_idx),
        .src_b_idx (src_b_idx),
        .wr_en     (wr_en),
        .wr_scalar (wr_scalar),
        .wr_data   (wr_data),
        .rd_a_data (rd_a_data),
        .rd_b_data (rd_b_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [127:0] merged(logic [127:0] old, logic [127:0] d, logic scl);
        return scl ? {old[127:32], d[31:0]} : d;
    endfunction

    function automatic logic [127:0] rand_vec();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One operation: drive, check the bypassed reads, then update the model at the edge.
    task automatic op(int a, int b, bit en, bit scl, logic [127:0] d, string tag);
        logic [127:0] ea, eb;
        string ta, tb;
        @(negedge clk);
        src_a_idx = 3'(a); src_b_idx = 3'(b);
        wr_en = en; wr_scalar = scl; wr_data = d;
        #1;
        ea = en ? merged(model[a], d, scl) : model[a];
        eb = (en && a == b) ? merged(model[b], d, scl) : model[b];
        ta = (tag != "") ? tag : (en ? "R6 port A bypass" : "R2 R3 R8 port A stored");
        tb = (tag != "") ? tag : ((en && a == b) ? "R7 port B bypass" : "R2 R3 R8 port B stored");
        chk(ta, rd_a_data, ea);
        chk(tb, rd_b_data, eb);
        @(posedge clk);
        if (en) model[a] = merged(model[a], d, scl);
    endtask

    task automatic read_all(string tag);
        for (int i = 0; i < NREG; i++) op(i, NREG-1-i, 1'b0, 1'b0, rand_vec(), tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b1; wr_scalar = 1'b0; wr_data = '1; src_a_idx = 3'd4;
        repeat (2) @(posedge clk);
        for (int i = 0; i < NREG; i++) model[i] = '0;
        @(negedge clk);
        rst_n = 1'b1; wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] v;
        void'($urandom(32'd7731));
        for (int i = 0; i < NREG; i++) model[i] = 'x;
        do_reset();
        read_all("R1 reset clears");

        // R2 and R9: a packed write with distinct lanes, then lane 1 read on port B.
        v = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
        op(3, 0, 1'b1, 1'b0, v, "");
        @(negedge clk);
        src_a_idx = 3'd0; src_b_idx = 3'd3; wr_en = 1'b0;
        #1;
        chk("R9 lane 1 position", {96'd0, rd_b_data[63:32]}, {96'd0, 32'h2222_2222});
        chk("R2 packed write stored", rd_b_data, v);

        // R3: a scalar write keeps the upper lanes.
        op(3, 3, 1'b1, 1'b1, rand_vec(), "");
        op(0, 3, 1'b0, 1'b0, '0, "R3 scalar keeps upper lanes");

        // R5: write enable low with busy data leaves every register unchanged.
        op(3, 3, 1'b0, 1'b0, '1, "R5 no write when enable low");
        op(3, 3, 1'b0, 1'b1, '1, "R5 no write when enable low");
        read_all("R5 all registers unchanged");

        // R4: the destination follows src_a; the others are untouched.
        op(5, 2, 1'b1, 1'b0, rand_vec(), "");
        read_all("R4 only src_a register written");

        // R6 and R7: back-to-back writes to one register with both ports on it.
        op(6, 6, 1'b1, 1'b0, rand_vec(), "");
        op(6, 6, 1'b1, 1'b1, rand_vec(), "");

        // Random mix of operations.
        for (int n = 0; n < 400; n++)
            op($urandom % NREG, $urandom % NREG, ($urandom % 4) != 0, $urandom % 2, rand_vec(), "");
        read_all("R8 final contents");

        // R1: reset during an active write wins and clears everything.
        do_reset();
        read_all("R1 reset beats write");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule